// File: doc/BRIEF.md
# UART Software Reset Controller

This block sits behind one word of a UART's register space and turns software writes into reset actions. Software can flush the transmit queue, flush the receive queue, or reset the whole peripheral, all with a single store. It never has to read back the other queue-control fields or write a zero to end the action. Both queue flushes are one-cycle pulses in the bus clock domain. Each flush pulse also clears the DMA request of its direction, so a DMA engine does not keep asking for data that has just been thrown away.

A whole-peripheral reset request is stretched for a fixed number of bus clock cycles. It forces the reset outputs of both the bus clock domain and the serial clock domain high at once. Each domain then lets go of its reset through its own two-stage synchronizer. Reads of the word always return zero, because every implemented bit is write-only.

Top module: `uart_srst_ctrl`

## Requirements
- R1: A write takes effect only when `reg_wen` is high and `reg_addr` equals `REG_OFFSET` (default 0x088). Bits 31:3 of `reg_wdata` are ignored, and a write with only those bits set produces no output activity.
- R2: A write with bit 2 set, while `fifos_enabled` is high, drives `txq_flush` high for exactly the one bus cycle that follows the write edge.
- R3: A write with bit 1 set, while `fifos_enabled` is high, drives `rxq_flush` high for exactly the one bus cycle that follows the write edge.
- R4: While `fifos_enabled` is low, bits 2 and 1 have no effect: `txq_flush`, `rxq_flush`, `txq_dma_clr` and `rxq_dma_clr` all stay low.
- R5: `txq_dma_clr` pulses in the same cycle as every `txq_flush` pulse.
- R6: `rxq_dma_clr` pulses together with `rxq_flush` only when `dma_hs_extra` was high in the write cycle. Otherwise it stays low.
- R7: The flush bits clear themselves. Bits 2 and 1 set in one write give both pulses in the same cycle. Writes on consecutive cycles give one pulse each, on consecutive cycles.
- R8: A write with bit 0 set drives `bus_rst_out` and `ser_rst_out` high from the bus edge that takes the write, without waiting for a serial clock edge.
- R9: The bit-0 request stays active for `HOLD_CYCLES` bus cycles, and a new bit-0 write restarts that count. `bus_rst_out` falls on the second bus edge after the request ends.
- R10: `ser_rst_out` stays high while the request is active and falls on the second serial clock edge after the request ends.
- R11: `bus_rst` sets `bus_rst_out` at a bus edge and cancels any pending request. `ser_rst` sets `ser_rst_out` at a serial edge. Each output falls on the second edge of its own clock after its reset input is released.
- R12: `reg_rdata` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| ser_clk | input | 1 | Serial clock |
| ser_rst | input | 1 | Synchronous active-high reset, serial domain |
| reg_wen | input | 1 | Register write enable |
| reg_addr | input | ADDR_W (12) | Register byte address |
| reg_wdata | input | DATA_W (32) | Write data: bit 2 transmit flush, bit 1 receive flush, bit 0 full reset |
| reg_rdata | output | DATA_W (32) | Read data, always zero |
| fifos_enabled | input | 1 | High when the UART has queues |
| dma_hs_extra | input | 1 | High when the extra receive DMA handshake is in use |
| txq_flush | output | 1 | One-cycle transmit queue clear |
| txq_dma_clr | output | 1 | One-cycle transmit DMA request clear |
| rxq_flush | output | 1 | One-cycle receive queue clear |
| rxq_dma_clr | output | 1 | One-cycle receive DMA request clear |
| bus_rst_out | output | 1 | Peripheral reset for the bus domain |
| ser_rst_out | output | 1 | Peripheral reset for the serial domain |

## Verification
A flush and a whole-peripheral reset can be asked for in the same cycle. The bench provokes this with a single write of 0x7. It then checks that both flush pulses appear in the cycle after the write, and that both domain resets rise in that same cycle and release on their own schedules. The two flushes also coincide, both inside one write and on back-to-back writes, and each pulse is judged every cycle against a behavioural model. A request retriggered while still active, and a bus reset arriving during a request, are compared cycle by cycle in the same way.

// File: rtl/uart_srst_pkg.sv
package uart_srst_pkg;

    // Field positions inside the control word
    localparam int TXF_POS   = 2;
    localparam int RXF_POS   = 1;
    localparam int FULL_POS  = 0;
    localparam int CTRL_BITS = 3;

    typedef struct packed {
        logic tx_flush;
        logic rx_flush;
        logic full_rst;
    } srst_cmd_t;

    localparam srst_cmd_t CMD_NONE = '0;

    typedef struct packed {
        logic tx_fifo;
        logic tx_dma;
        logic rx_fifo;
        logic rx_dma;
    } clr_pulse_t;

    function automatic srst_cmd_t decode_ctrl(input logic [CTRL_BITS-1:0] bits,
                                              input logic fifos);
        srst_cmd_t c;
        c.tx_flush = bits[TXF_POS] & fifos;
        c.rx_flush = bits[RXF_POS] & fifos;
        c.full_rst = bits[FULL_POS];
        return c;
    endfunction

endpackage

// File: rtl/srst_decode.sv
module srst_decode
    import uart_srst_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h088
) (
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fifos,
    output srst_cmd_t         cmd
);
    logic hit;
    logic unused_rsvd;

    assign hit         = wen && (addr == REG_OFFSET);
    assign unused_rsvd = ^wdata[DATA_W-1:CTRL_BITS];
    assign cmd         = hit ? decode_ctrl(wdata[CTRL_BITS-1:0], fifos) : CMD_NONE;
endmodule

// File: rtl/srst_pulse_gen.sv
module srst_pulse_gen
    import uart_srst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  srst_cmd_t  cmd,
    input  logic       dma_extra,
    output clr_pulse_t pulses
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulses <= '0;
        end else begin
            pulses.tx_fifo <= cmd.tx_flush;
            pulses.tx_dma  <= cmd.tx_flush;
            pulses.rx_fifo <= cmd.rx_flush;
            pulses.rx_dma  <= cmd.rx_flush & dma_extra;
        end
    end
endmodule

// File: rtl/srst_hold.sv
module srst_hold #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic req
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(HOLD_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign req = (cnt != '0);
endmodule

// File: rtl/srst_rst_sync.sv
module srst_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic sync_rst,
    input  logic async_set,
    output logic rst_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge async_set) begin
        if (async_set) begin
            chain <= '1;
        end else if (sync_rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b0};
        end
    end

    assign rst_out = chain[STAGES-1];
endmodule

// File: rtl/uart_srst_ctrl.sv
module uart_srst_ctrl
    import uart_srst_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h088,
    parameter int HOLD_CYCLES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              ser_clk,
    input  logic              ser_rst,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              fifos_enabled,
    input  logic              dma_hs_extra,
    output logic              txq_flush,
    output logic              txq_dma_clr,
    output logic              rxq_flush,
    output logic              rxq_dma_clr,
    output logic              bus_rst_out,
    output logic              ser_rst_out
);
    srst_cmd_t  cmd;
    clr_pulse_t pulses;
    logic       full_req;

    srst_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .REG_OFFSET(REG_OFFSET)
    ) u_decode (
        .wen  (reg_wen),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .fifos(fifos_enabled),
        .cmd  (cmd)
    );

    srst_pulse_gen u_pulse (
        .clk      (bus_clk),
        .rst      (bus_rst),
        .cmd      (cmd),
        .dma_extra(dma_hs_extra),
        .pulses   (pulses)
    );

    srst_hold #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_hold (
        .clk  (bus_clk),
        .rst  (bus_rst),
        .start(cmd.full_rst),
        .req  (full_req)
    );

    srst_rst_sync #(
        .STAGES(SYNC_STAGES)
    ) u_bus_sync (
        .clk      (bus_clk),
        .sync_rst (bus_rst),
        .async_set(full_req),
        .rst_out  (bus_rst_out)
    );

    srst_rst_sync #(
        .STAGES(SYNC_STAGES)
    ) u_ser_sync (
        .clk      (ser_clk),
        .sync_rst (ser_rst),
        .async_set(full_req),
        .rst_out  (ser_rst_out)
    );

    assign txq_flush   = pulses.tx_fifo;
    assign txq_dma_clr = pulses.tx_dma;
    assign rxq_flush   = pulses.rx_fifo;
    assign rxq_dma_clr = pulses.rx_dma;
    assign reg_rdata   = '0;
endmodule

module uart_srst_ctrl_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h088
) (
    input logic              bus_clk,
    input logic              bus_rst,
    input logic              reg_wen,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              fifos_enabled,
    input logic              dma_hs_extra,
    input logic              txq_flush,
    input logic              rxq_flush,
    input logic              rxq_dma_clr,
    input logic              bus_rst_out,
    input logic              ser_rst_out
);
    logic hit;
    assign hit = reg_wen && (reg_addr == REG_OFFSET);

    // R2
    tx_flush_pulse_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        txq_flush == $past(hit && reg_wdata[2] && fifos_enabled));

    // R3
    rx_flush_pulse_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        rxq_flush == $past(hit && reg_wdata[1] && fifos_enabled));

    // R4
    no_fifo_quiet_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $past(!fifos_enabled) |-> (!txq_flush && !rxq_flush && !rxq_dma_clr));

    // R6
    rx_dma_gate_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        rxq_dma_clr == $past(hit && reg_wdata[1] && fifos_enabled && dma_hs_extra));

    // R8
    full_rst_now_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (hit && reg_wdata[0]) |=> (bus_rst_out && ser_rst_out));

    // R9
    full_rst_held_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $past(hit && reg_wdata[0], 2) |-> bus_rst_out);
endmodule

bind uart_srst_ctrl uart_srst_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .REG_OFFSET(REG_OFFSET)
) u_chk (
    .bus_clk      (bus_clk),
    .bus_rst      (bus_rst),
    .reg_wen      (reg_wen),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .fifos_enabled(fifos_enabled),
    .dma_hs_extra (dma_hs_extra),
    .txq_flush    (txq_flush),
    .rxq_flush    (rxq_flush),
    .rxq_dma_clr  (rxq_dma_clr),
    .bus_rst_out  (bus_rst_out),
    .ser_rst_out  (ser_rst_out)
);

// File: tb/uart_srst_ctrl_test.sv
`timescale 1ns/1ps
module uart_srst_ctrl_test;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] OFS = 12'h088;
    localparam int HOLD = 8;
    localparam int STG  = 2;

    logic bus_clk = 1'b0;
    logic ser_clk = 1'b0;
    logic bus_rst = 1'b1;
    logic ser_rst = 1'b1;
    logic reg_wen = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic fifos_enabled = 1'b1;
    logic dma_hs_extra = 1'b0;
    logic txq_flush, txq_dma_clr, rxq_flush, rxq_dma_clr, bus_rst_out, ser_rst_out;

    uart_srst_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(OFS),
        .HOLD_CYCLES(HOLD), .SYNC_STAGES(STG)
    ) uut (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .ser_clk(ser_clk), .ser_rst(ser_rst),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fifos_enabled(fifos_enabled),
        .dma_hs_extra(dma_hs_extra), .txq_flush(txq_flush),
        .txq_dma_clr(txq_dma_clr), .rxq_flush(rxq_flush),
        .rxq_dma_clr(rxq_dma_clr), .bus_rst_out(bus_rst_out),
        .ser_rst_out(ser_rst_out)
    );

    // 200 MHz bus clock; slower serial clock whose edges never meet bus edges
    always #2.5 bus_clk = ~bus_clk;
    initial begin
        #1.25;
        forever #9 ser_clk = ~ser_clk;
    end

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit checking = 1'b0;
    string phase = "R1";

    // Reference model state
    bit e_tx, e_txd, e_rx, e_rxd;
    int m_req = 0;
    int m_pcnt = STG;
    int m_scnt = STG;

    always @(posedge bus_clk) begin
        bit hit;
        hit = reg_wen && (reg_addr == OFS);
        e_tx  = hit && reg_wdata[2] && fifos_enabled && !bus_rst;
        e_txd = e_tx;
        e_rx  = hit && reg_wdata[1] && fifos_enabled && !bus_rst;
        e_rxd = e_rx && dma_hs_extra;
        if (bus_rst || m_req > 0) m_pcnt = STG;
        else if (m_pcnt > 0) m_pcnt = m_pcnt - 1;
        if (bus_rst) m_req = 0;
        else if (hit && reg_wdata[0]) m_req = HOLD;
        else if (m_req > 0) m_req = m_req - 1;
    end

    always @(posedge ser_clk) begin
        if (ser_rst || m_req > 0) m_scnt = STG;
        else if (m_scnt > 0) m_scnt = m_scnt - 1;
    end

    task automatic cmp(input string tag, input logic got, input bit exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s (phase %s) t=%0t got %b expected %b", tag, phase, $time, got, exp);
        end
    endtask

    always @(negedge bus_clk) begin
        cycles++;
        if (checking) begin
            cmp("R2 txq_flush", txq_flush, e_tx);
            cmp("R5 txq_dma_clr", txq_dma_clr, e_txd);
            cmp("R3 rxq_flush", rxq_flush, e_rx);
            cmp("R6 rxq_dma_clr", rxq_dma_clr, e_rxd);
            cmp("R8/R9 bus_rst_out", bus_rst_out, (m_req > 0) || (m_pcnt > 0));
            cmp("R8/R10 ser_rst_out", ser_rst_out, (m_req > 0) || (m_scnt > 0));
            compared++;
            if (reg_rdata !== '0) begin
                mismatched++;
                $display("FAIL R12 (phase %s) reg_rdata got %h expected 0", phase, reg_rdata);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic en);
        @(negedge bus_clk);
        reg_wen = en; reg_addr = a; reg_wdata = d;
        @(negedge bus_clk);
        reg_wen = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        repeat (4) @(negedge ser_clk);
        ser_rst = 1'b0;
    end

    initial begin
        idle(6);
        bus_rst = 1'b0;
        idle(12);
        checking = 1'b1;   // reset state of all outputs compared from here (R11)

        phase = "R1";
        wr(12'h08C, 32'h7, 1'b1);
        wr(OFS, 32'h7, 1'b0);
        wr(OFS, 32'hFFFF_FFF8, 1'b1);
        idle(4);

        phase = "R2";
        wr(OFS, 32'h4, 1'b1);
        idle(3);
        phase = "R3";
        wr(OFS, 32'h2, 1'b1);
        idle(3);
        phase = "R6";
        dma_hs_extra = 1'b1;
        wr(OFS, 32'h2, 1'b1);
        idle(2);
        phase = "R5";
        wr(OFS, 32'h4, 1'b1);
        idle(2);

        phase = "R7";
        wr(OFS, 32'h6, 1'b1);
        @(negedge bus_clk);
        reg_wen = 1'b1; reg_addr = OFS; reg_wdata = 32'h4;
        @(negedge bus_clk);
        reg_wdata = 32'h2;
        @(negedge bus_clk);
        reg_wen = 1'b0; reg_wdata = '0;
        idle(3);

        phase = "R4";
        fifos_enabled = 1'b0;
        wr(OFS, 32'h6, 1'b1);
        idle(3);
        fifos_enabled = 1'b1;

        phase = "R8";
        wr(OFS, 32'h1, 1'b1);
        idle(20);
        phase = "R10";
        wr(OFS, 32'h7, 1'b1);
        idle(20);
        phase = "R9";
        wr(OFS, 32'h1, 1'b1);
        idle(4);
        wr(OFS, 32'h1, 1'b1);
        idle(20);

        phase = "R11";
        wr(OFS, 32'h1, 1'b1);
        idle(2);
        bus_rst = 1'b1;
        idle(3);
        bus_rst = 1'b0;
        idle(10);
        @(negedge ser_clk);
        ser_rst = 1'b1;
        repeat (2) @(negedge ser_clk);
        ser_rst = 1'b0;
        idle(20);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #100000;
        mismatched++;
        $display("FAIL watchdog expired at t=%0t", $time);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule